// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block moves a requested number of bytes between a local buffer and host memory. The host describes the memory side as a table of 8-byte region descriptors. The walker reads descriptors from memory one at a time through a simple read-request port. It cuts each region into burst requests for an external data mover. Each request carries an address, a length and a direction. The walker tracks three things about the current region: its address, how many bytes of it remain, and whether it is the final entry of the table.

A transfer starts with a one-cycle `start` pulse that carries the byte count and the direction. The walker completes when the count is used up, or reports an underrun when the table ends first. Region state survives between transfers. A later transfer therefore continues inside a region that an earlier one left partly used. A `restart` pulse rewinds the table pointer to the table base and drops any partly used region. Two limits end the table early. One is the end-of-table bit of the last descriptor. The other is a safety cap: the walk never reads descriptors beyond one page past the table base.

Top module: `prd_walker`

## Requirements
- R1: After reset, `busy`, `done`, `underrun`, `rd_req` and `bst_req` are all low, and the table pointer equals `tbl_base`.
- R2: A descriptor arrives on `rd_data` with `rd_ack`. Bits 31:0 give the region base address and bits 47:32 give the length, with bit 0 of the length forced to zero. Bit 63 marks the last entry. The other bits are ignored.
- R3: A length field that is zero after bit 0 is cleared (for example 0x0000 or 0x0001) stands for a 65536-byte region.
- R4: A descriptor is fetched only when the current region has no bytes left. Each fetch reads address `rd_addr`, and the pointer then advances by 8.
- R5: Each burst length is the smaller of the bytes still to move and the region bytes left. The region address then advances by that amount, and the region bytes left drop by the same amount. Bytes left in a region carry over to the next transfer.
- R6: The walker may need a new region after it has consumed a descriptor with bit 63 set. In that case it fetches nothing, ends the transfer, and reports `underrun` high.
- R7: No descriptor is fetched once the table pointer is PAGE_BYTES (4096) or more past `tbl_base`. In that case the transfer ends with `underrun` high.
- R8: When the requested count is used up, `done` pulses for one cycle with `underrun` low. A transfer of zero bytes completes this way with no fetch and no burst.
- R9: Only one request is outstanding at a time. `rd_req` and `bst_req` are never high together, and each stays high with a stable address and length until its acknowledge.
- R10: A `restart` while idle reloads the pointer from `tbl_base` and empties the current region, so the next transfer fetches from the table base again.
- R11: `bst_dir` of every burst equals the `xfer_dir` captured with `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | ADDR_W | Descriptor table base address |
| restart | input | 1 | Rewind the table and empty the region (idle only) |
| start | input | 1 | Begin a transfer (idle only) |
| xfer_len | input | CNT_W | Bytes to move in this transfer |
| xfer_dir | input | 1 | Direction of the transfer, copied to every burst |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | ADDR_W | Address of the descriptor to read |
| rd_ack | input | 1 | Descriptor read accepted, data valid |
| rd_data | input | 64 | Descriptor contents |
| bst_req | output | 1 | Burst request to the data mover |
| bst_addr | output | ADDR_W | Burst host address |
| bst_len | output | 17 | Burst length in bytes |
| bst_dir | output | 1 | Burst direction |
| bst_ack | input | 1 | Burst finished |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| underrun | output | 1 | Last transfer ended because the table ran out |

## Verification
The first pattern is a single region that matches the request exactly. This shows that the walker completes without touching the next descriptor. The second pattern splits a request over two regions, and the first region has an odd length field. This exposes whether bit 0 is cleared and whether the burst is sized by the smaller of the two counts. Three short transfers follow on the same table. They separate carry-over of a partly used region, end-of-table underrun without a fetch, and rewind by restart. A field of 0x0001 tests the 64 KiB encoding. A table of 512 entries with no last bit tests the page cap. A zero-byte request tests completion without any memory traffic.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;
  localparam int unsigned REGION_W = 17;
  localparam int unsigned DESC_BYTES = 8;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_DECIDE,
    WS_FETCH,
    WS_MOVE
  } walk_state_e;
endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode
  import prd_walk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [63:0]         word,
  output logic [ADDR_W-1:0]   region_base,
  output logic [REGION_W-1:0] region_len,
  output logic                region_last
);
  logic [15:0] even_len;

  assign even_len    = {word[47:33], 1'b0};
  assign region_base = word[ADDR_W-1:0];
  assign region_last = word[63];
  // an all-zero even length encodes the largest region, 64 KiB
  assign region_len  = (even_len == 16'd0) ? REGION_W'(17'h10000)
                                           : REGION_W'(even_len);

  generate
    if (ADDR_W < 32) begin : g_short_addr
      logic unused_hi;
      assign unused_hi = ^{word[62:48], word[32], word[31:ADDR_W]};
    end else begin : g_full_addr
      logic unused_hi;
      assign unused_hi = ^{word[62:48], word[32]};
    end
  endgenerate
endmodule

// File: rtl/prd_tbl_ptr.sv
module prd_tbl_ptr #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int STEP       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic              load,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr,
  output logic              cap_hit
);
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      ptr <= base;
    end else if (advance) begin
      ptr <= ptr + ADDR_W'(STEP);
    end
  end

  assign offset  = ptr - base;
  assign cap_hit = (offset >= ADDR_W'(PAGE_BYTES));
endmodule

// File: rtl/prd_burst_size.sv
module prd_burst_size
  import prd_walk_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0]    remain,
  input  logic [REGION_W-1:0] region,
  output logic [REGION_W-1:0] step
);
  generate
    if (CNT_W > REGION_W) begin : g_wide
      assign step = (remain < CNT_W'(region)) ? remain[REGION_W-1:0] : region;
    end else begin : g_narrow
      assign step = (REGION_W'(remain) < region) ? REGION_W'(remain) : region;
    end
  endgenerate
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   tbl_base,
  input  logic                restart,
  input  logic                start,
  input  logic [CNT_W-1:0]    xfer_len,
  input  logic                xfer_dir,
  output logic                rd_req,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_ack,
  input  logic [63:0]         rd_data,
  output logic                bst_req,
  output logic [ADDR_W-1:0]   bst_addr,
  output logic [REGION_W-1:0] bst_len,
  output logic                bst_dir,
  input  logic                bst_ack,
  output logic                busy,
  output logic                done,
  output logic                underrun
);
  walk_state_e         state;
  logic [CNT_W-1:0]    remain;
  logic [ADDR_W-1:0]   reg_addr;
  logic [REGION_W-1:0] reg_len;
  logic                reg_last;

  logic [ADDR_W-1:0]   dec_base;
  logic [REGION_W-1:0] dec_len;
  logic                dec_last;
  logic [REGION_W-1:0] step;
  logic                ptr_load;
  logic                ptr_adv;
  logic                cap_hit;

  assign ptr_load = (state == WS_IDLE) && restart;
  assign ptr_adv  = (state == WS_FETCH) && rd_ack;

  prd_desc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word        (rd_data),
    .region_base (dec_base),
    .region_len  (dec_len),
    .region_last (dec_last)
  );

  prd_tbl_ptr #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .STEP       (DESC_BYTES)
  ) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .base    (tbl_base),
    .load    (ptr_load),
    .advance (ptr_adv),
    .ptr     (rd_addr),
    .cap_hit (cap_hit)
  );

  prd_burst_size #(.CNT_W(CNT_W)) u_size (
    .remain (remain),
    .region (reg_len),
    .step   (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WS_IDLE;
      remain   <= '0;
      reg_addr <= '0;
      reg_len  <= '0;
      reg_last <= 1'b0;
      rd_req   <= 1'b0;
      bst_req  <= 1'b0;
      bst_addr <= '0;
      bst_len  <= '0;
      bst_dir  <= 1'b0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        WS_IDLE: begin
          if (restart) begin
            reg_addr <= '0;
            reg_len  <= '0;
            reg_last <= 1'b0;
          end else if (start) begin
            remain   <= xfer_len;
            bst_dir  <= xfer_dir;
            underrun <= 1'b0;
            state    <= WS_DECIDE;
          end
        end
        WS_DECIDE: begin
          if (remain == '0) begin
            done  <= 1'b1;
            state <= WS_IDLE;
          end else if (reg_len == '0) begin
            if (reg_last || cap_hit) begin
              underrun <= 1'b1;
              done     <= 1'b1;
              state    <= WS_IDLE;
            end else begin
              rd_req <= 1'b1;
              state  <= WS_FETCH;
            end
          end else begin
            bst_req  <= 1'b1;
            bst_addr <= reg_addr;
            bst_len  <= step;
            state    <= WS_MOVE;
          end
        end
        WS_FETCH: begin
          if (rd_ack) begin
            rd_req   <= 1'b0;
            reg_addr <= dec_base;
            reg_len  <= dec_len;
            reg_last <= dec_last;
            state    <= WS_DECIDE;
          end
        end
        WS_MOVE: begin
          if (bst_ack) begin
            bst_req  <= 1'b0;
            reg_addr <= reg_addr + ADDR_W'(bst_len);
            reg_len  <= reg_len - bst_len;
            remain   <= remain - CNT_W'(bst_len);
            state    <= WS_DECIDE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign busy = (state != WS_IDLE);
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] tbl_base,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              bst_req,
  input logic [ADDR_W-1:0] bst_addr,
  input logic [16:0]       bst_len,
  input logic              bst_ack,
  input logic              busy,
  input logic              done
);
  assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  assert_burst_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bst_req && !bst_ack |=> bst_req && $stable(bst_addr) && $stable(bst_len));

  assert_one_request_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && bst_req));

  assert_burst_bounds_R5: assert property (@(posedge clk) disable iff (rst)
    bst_req |-> (bst_len != 17'd0) && (bst_len <= 17'h10000));

  assert_page_cap_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ((rd_addr - tbl_base) < ADDR_W'(PAGE_BYTES)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !rd_req && !bst_req);
endmodule

bind prd_walker prd_walker_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tbl_base (tbl_base),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_ack   (rd_ack),
  .bst_req  (bst_req),
  .bst_addr (bst_addr),
  .bst_len  (bst_len),
  .bst_ack  (bst_ack),
  .busy     (busy),
  .done     (done)
);

// File: tb/prd_walker_test.sv
`timescale 1ns/1ps
module prd_walker_test;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 20;
  localparam logic [31:0] TBASE = 32'h0004_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] tbl_base = TBASE;
  logic              restart = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  xfer_len = '0;
  logic              xfer_dir = 1'b0;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_ack = 1'b0;
  logic [63:0]       rd_data = '0;
  logic              bst_req;
  logic [ADDR_W-1:0] bst_addr;
  logic [16:0]       bst_len;
  logic              bst_dir;
  logic              bst_ack = 1'b0;
  logic              busy, done, underrun;

  int total = 0;
  int bad = 0;

  logic [31:0] tab_a [0:511];
  logic [31:0] tab_w [0:511];

  int          n_fetch;
  logic [31:0] first_fetch, last_fetch;
  int          n_bst;
  logic [31:0] log_a [0:1023];
  logic [16:0] log_l [0:1023];
  logic        log_d [0:1023];
  int          bytes_moved;
  int          overlap = 0;

  prd_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(4096)) uut (
    .clk(clk), .rst(rst), .tbl_base(tbl_base), .restart(restart), .start(start),
    .xfer_len(xfer_len), .xfer_dir(xfer_dir), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .bst_req(bst_req), .bst_addr(bst_addr),
    .bst_len(bst_len), .bst_dir(bst_dir), .bst_ack(bst_ack), .busy(busy),
    .done(done), .underrun(underrun)
  );

  initial forever #2.5 clk = ~clk;

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finish_run();
  end

  // memory and data mover responders
  initial forever begin
    @(negedge clk);
    if (rd_req && bst_req) overlap++;
    if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rd_req) begin
      int idx;
      idx = int'((rd_addr - TBASE) >> 3);
      if (idx >= 0 && idx < 512) rd_data = {tab_w[idx], tab_a[idx]};
      else rd_data = '0;
      if (n_fetch == 0) first_fetch = rd_addr;
      last_fetch = rd_addr;
      n_fetch++;
      rd_ack = 1'b1;
    end
    if (bst_ack) begin
      bst_ack = 1'b0;
    end else if (bst_req) begin
      if (n_bst < 1024) begin
        log_a[n_bst] = bst_addr;
        log_l[n_bst] = bst_len;
        log_d[n_bst] = bst_dir;
      end
      n_bst++;
      bytes_moved += int'(bst_len);
      bst_ack = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_fetch = 0; n_bst = 0; bytes_moved = 0;
    first_fetch = '0; last_fetch = '0;
  endtask

  task automatic clear_table();
    for (int i = 0; i < 512; i++) begin
      tab_a[i] = '0;
      tab_w[i] = '0;
    end
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic run_xfer(input int len, input bit dir);
    clear_logs();
    @(negedge clk);
    xfer_len = CNT_W'(len); xfer_dir = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !underrun, "R1 idle flags", {busy, done, underrun}, 0);
    chk(!rd_req && !bst_req, "R1 no requests", {rd_req, bst_req}, 0);
    chk(rd_addr == TBASE, "R1 pointer at base", rd_addr, TBASE);
  endtask

  task automatic t_single();
    clear_table();
    tab_a[0] = 32'h0000_1000; tab_w[0] = 32'h8000_0200;
    do_restart();
    run_xfer(32'h200, 1'b1);
    chk(underrun == 1'b0, "R8 exact completion", underrun, 0);
    chk(n_fetch == 1 && first_fetch == TBASE, "R4 one fetch at base", first_fetch, TBASE);
    chk(n_bst == 1 && log_a[0] == 32'h1000 && log_l[0] == 17'h200, "R2 region decode",
        {log_a[0], 15'd0, log_l[0]}, {32'h1000, 15'd0, 17'h200});
    chk(log_d[0] == 1'b1, "R11 write direction", log_d[0], 1);
  endtask

  task automatic t_split();
    clear_table();
    tab_a[0] = 32'h0000_2000; tab_w[0] = 32'h0000_0101;
    tab_a[1] = 32'h0000_8000; tab_w[1] = 32'h8000_0300;
    do_restart();
    run_xfer(32'h300, 1'b0);
    chk(underrun == 1'b0, "R8 split completes", underrun, 0);
    chk(n_fetch == 2 && last_fetch == TBASE + 8, "R4 pointer step 8", last_fetch, TBASE + 8);
    chk(n_bst == 2 && log_l[0] == 17'h100 && log_a[0] == 32'h2000, "R2 length bit 0 cleared",
        log_l[0], 17'h100);
    chk(log_a[1] == 32'h8000 && log_l[1] == 17'h200, "R5 burst clipped to remaining",
        log_l[1], 17'h200);
    chk(log_d[0] == 1'b0 && log_d[1] == 1'b0, "R11 read direction", {log_d[0], log_d[1]}, 0);
    run_xfer(32'h100, 1'b0);
    chk(n_fetch == 0, "R4 no fetch while region left", n_fetch, 0);
    chk(n_bst == 1 && log_a[0] == 32'h8200 && log_l[0] == 17'h100, "R5 leftover carries over",
        log_a[0], 32'h8200);
    chk(underrun == 1'b0, "R8 leftover completes", underrun, 0);
    run_xfer(32'h10, 1'b0);
    chk(underrun == 1'b1, "R6 last flag underrun", underrun, 1);
    chk(n_fetch == 0 && n_bst == 0, "R6 nothing after last", n_fetch + n_bst, 0);
  endtask

  task automatic t_restart();
    do_restart();
    run_xfer(32'h40, 1'b0);
    chk(n_fetch == 1 && first_fetch == TBASE, "R10 restart rewinds", first_fetch, TBASE);
    chk(n_bst == 1 && log_a[0] == 32'h2000 && log_l[0] == 17'h40, "R10 fresh region",
        log_a[0], 32'h2000);
  endtask

  task automatic t_big();
    clear_table();
    tab_a[0] = 32'h0010_0000; tab_w[0] = 32'h8000_0001;
    do_restart();
    run_xfer(32'h10004, 1'b0);
    chk(n_bst == 1 && log_l[0] == 17'h10000, "R3 odd 1 means 64 KiB", log_l[0], 17'h10000);
    chk(underrun == 1'b1, "R6 underrun after big region", underrun, 1);
  endtask

  task automatic t_cap();
    clear_table();
    for (int i = 0; i < 512; i++) begin
      tab_a[i] = 32'h0100_0000 + 32'(i * 16);
      tab_w[i] = 32'h0000_0002;
    end
    do_restart();
    run_xfer(2000, 1'b1);
    chk(n_fetch == 512, "R7 fetch count capped", n_fetch, 512);
    chk(last_fetch == TBASE + 32'd4088, "R7 last fetch address", last_fetch, TBASE + 32'd4088);
    chk(bytes_moved == 1024 && underrun == 1'b1, "R7 capped underrun", bytes_moved, 1024);
  endtask

  task automatic t_zero();
    do_restart();
    run_xfer(0, 1'b0);
    chk(n_fetch == 0 && n_bst == 0, "R8 zero count no traffic", n_fetch + n_bst, 0);
    chk(underrun == 1'b0, "R8 zero count completes", underrun, 0);
  endtask

  initial begin
    clear_logs();
    clear_table();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_restart();
    t_big();
    t_cap();
    t_zero();
    chk(overlap == 0, "R9 one request at a time", overlap, 0);
    finish_run();
  end
endmodule